// File: doc/BRIEF.md
# Masked Multi-Level Interrupt Aggregator

This block gathers thirteen hardware interrupt sources into one 32-bit pending register. Each source owns a fixed bit, and the bits are scattered sparsely over the word. A 32-bit enable register, with one bit per pending bit, selects which pending bits may reach the processor. Both registers sit on a simple register bus, and software can read and write them.

The enabled pending bits fall into three priority groups, called low (level 3), middle (level 5) and high (level 6). The block drives the highest group that has any enabled pending bit toward the processor, together with that group's autovector number. A pending bit follows its source's level on every cycle. A bus write to the pending register takes precedence for that one cycle. After that, the sources take over their own bits again.

Top module: `irq_level_agg`

## Requirements
- R1: After reset the pending and enable registers are all zero, and `level_o` and `vector_o` are 0.
- R2: Low-group sources drive these pending bits: `src_i[0]` bit 7, `src_i[1]` bit 3, `src_i[2]` bit 2, `src_i[3]` bit 9, `src_i[4]` bit 10, `src_i[5]` bit 12, `src_i[6]` bit 5.
- R3: `src_i[7]` drives bit 17, which is the only middle-group bit. High-group sources drive these bits: `src_i[8]` bit 28, `src_i[9]` bit 27, `src_i[10]` bit 26, `src_i[11]` bit 23, `src_i[12]` bit 21.
- R4: On a cycle with no pending-register write, each source-owned bit takes the value of its source at that clock edge. It is set while the source is high and cleared while it is low. Bits owned by no source keep their value.
- R5: A write with `wr_addr_i` = 0x7000 loads all 32 bits of `wr_data_i` into the pending register at that edge and ignores the sources for that cycle. On the next edge, source-owned bits follow their sources again, while unowned bits keep the written value.
- R6: A write with `wr_addr_i` = 0x7800 loads the enable register. The enable register changes on no other event.
- R7: A write to any other offset changes neither register.
- R8: `rd_data_o` shows the pending register when `rd_addr_i` = 0x7000 and the enable register when it is 0x7800. At any other offset it is zero. The read path is combinational.
- R9: A pending bit whose enable bit is 0 has no effect on `level_o`. With no enabled pending bit, `level_o` is 0 and `vector_o` is 0.
- R10: `level_o` is 6 if any high-group bit is enabled and pending. Otherwise it is 5 if the middle-group bit is, otherwise 3 if any low-group bit is.
- R11: `vector_o` is 27 when `level_o` is 3, 29 when it is 5, and 30 when it is 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 13 | Source request levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 16 | Write offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 16 | Read offset |
| rd_data_o | output | 32 | Read data |
| level_o | output | 3 | Priority level to processor |
| vector_o | output | 8 | Autovector number |

## Verification
The first sweep raises each source alone with every bit enabled. This separates the bit placement of every source and shows which group each one resolves to. Repeating that sweep with everything disabled, and again with only the source's own bit enabled, shows that the enable register gates each bit individually. A walk through all eight combinations of one source per group shows the ordering between the groups. Direct writes to the pending register, made against both high and low sources, separate the one-cycle override from the way owned and unowned bits recover on the next cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NSRC   = 13;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int LVL_W  = 3;
  localparam int VEC_W  = 8;

  localparam logic [LVL_W-1:0] LVL_NONE = 3'd0;
  localparam logic [LVL_W-1:0] LVL_LO   = 3'd3;
  localparam logic [LVL_W-1:0] LVL_MID  = 3'd5;
  localparam logic [LVL_W-1:0] LVL_HI   = 3'd6;

  // pending-bit position owned by source i
  function automatic int src_bit(input int i);
    case (i)
      0:  return 7;
      1:  return 3;
      2:  return 2;
      3:  return 9;
      4:  return 10;
      5:  return 12;
      6:  return 5;
      7:  return 17;
      8:  return 28;
      9:  return 27;
      10: return 26;
      11: return 23;
      default: return 21;
    endcase
  endfunction

  // priority group of source i
  function automatic logic [LVL_W-1:0] src_level(input int i);
    if (i < 7)       return LVL_LO;
    else if (i == 7) return LVL_MID;
    else             return LVL_HI;
  endfunction

  // place source levels onto their pending bits
  function automatic logic [DATA_W-1:0] scatter(input logic [NSRC-1:0] s);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++)
      if (s[i]) r[src_bit(i)] = 1'b1;
    return r;
  endfunction

  // all pending bits that belong to one group
  function automatic logic [DATA_W-1:0] group_mask(input logic [LVL_W-1:0] lvl);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++)
      if (src_level(i) == lvl) r[src_bit(i)] = 1'b1;
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] level_vector(input logic [LVL_W-1:0] lvl);
    case (lvl)
      LVL_LO:  return 8'd27;
      LVL_MID: return 8'd29;
      LVL_HI:  return 8'd30;
      default: return 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/irq_stat_reg.sv
module irq_stat_reg
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] src_vec,
  output logic [DATA_W-1:0] status
);
  localparam logic [DATA_W-1:0] OWNED = scatter({NSRC{1'b1}});

  assign src_vec = scatter(src);

  always_ff @(posedge clk) begin
    if (!rst_n)    status <= '0;
    else if (load) status <= load_data;
    else           status <= (status & ~OWNED) | src_vec;
  end
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_data;
  end
endmodule

// File: rtl/irq_level_resolve.sv
module irq_level_resolve
  import irq_agg_pkg::*;
(
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] mask,
  output logic              pend_hi,
  output logic              pend_mid,
  output logic              pend_lo,
  output logic [LVL_W-1:0]  level,
  output logic [VEC_W-1:0]  vector
);
  localparam logic [DATA_W-1:0] M_HI  = group_mask(LVL_HI);
  localparam logic [DATA_W-1:0] M_MID = group_mask(LVL_MID);
  localparam logic [DATA_W-1:0] M_LO  = group_mask(LVL_LO);

  logic [DATA_W-1:0] enabled;
  assign enabled  = status & mask;
  assign pend_hi  = |(enabled & M_HI);
  assign pend_mid = |(enabled & M_MID);
  assign pend_lo  = |(enabled & M_LO);

  always_comb begin
    if (pend_hi)       level = LVL_HI;
    else if (pend_mid) level = LVL_MID;
    else if (pend_lo)  level = LVL_LO;
    else               level = LVL_NONE;
  end

  assign vector = level_vector(level);
endmodule

// File: rtl/irq_level_agg.sv
module irq_level_agg
  import irq_agg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] STAT_OFS = 16'h7000,
  parameter logic [ADDR_W-1:0] MASK_OFS = 16'h7800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [LVL_W-1:0]  level_o,
  output logic [VEC_W-1:0]  vector_o
);
  logic              wr_stat, wr_mask;
  logic [DATA_W-1:0] status_q, mask_q, src_vec;
  logic              pend_hi, pend_mid, pend_lo;

  assign wr_stat = wr_en_i && (wr_addr_i == STAT_OFS);
  assign wr_mask = wr_en_i && (wr_addr_i == MASK_OFS);

  irq_stat_reg u_stat (
    .clk(clk), .rst_n(rst_n), .src(src_i), .load(wr_stat),
    .load_data(wr_data_i), .src_vec(src_vec), .status(status_q)
  );

  irq_cfg_reg u_mask (
    .clk(clk), .rst_n(rst_n), .load(wr_mask),
    .load_data(wr_data_i), .value(mask_q)
  );

  irq_level_resolve u_res (
    .status(status_q), .mask(mask_q), .pend_hi(pend_hi),
    .pend_mid(pend_mid), .pend_lo(pend_lo), .level(level_o), .vector(vector_o)
  );

  always_comb begin
    if (rd_addr_i == STAT_OFS)      rd_data_o = status_q;
    else if (rd_addr_i == MASK_OFS) rd_data_o = mask_q;
    else                            rd_data_o = '0;
  end
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
  import irq_agg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src_i,
  input logic              wr_stat,
  input logic              wr_mask,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] status,
  input logic [DATA_W-1:0] mask,
  input logic              pend_hi,
  input logic              pend_mid,
  input logic              pend_lo,
  input logic [LVL_W-1:0]  level_o,
  input logic [VEC_W-1:0]  vector_o
);
  a_r2_floppy_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i[0] && !wr_stat) |=> status[7]);
  a_r3_sound_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i[11] && !wr_stat) |=> status[23]);
  a_r4_clear_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_i[7] && !wr_stat) |=> !status[17]);
  a_r5_write_override: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (status == $past(wr_data_i)));
  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask == $past(wr_data_i)));
  a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask));
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & mask) == '0) |-> (level_o == LVL_NONE && vector_o == '0));
  a_r10_hi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pend_hi |-> (level_o == LVL_HI));
  a_r10_mid_over_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_hi && pend_mid) |-> (level_o == LVL_MID));
  a_r11_vector_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vector_o == 8'd27, vector_o == 8'd29, vector_o == 8'd30}) &&
    ((level_o == LVL_LO) == (vector_o == 8'd27)) &&
    ((level_o == LVL_HI) == (vector_o == 8'd30)));
  a_r10_no_lo_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_hi && !pend_mid && !pend_lo) |-> (level_o == LVL_NONE));
endmodule

bind irq_level_agg irq_agg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_stat(wr_stat),
  .wr_mask(wr_mask), .wr_data_i(wr_data_i), .status(status_q), .mask(mask_q),
  .pend_hi(pend_hi), .pend_mid(pend_mid), .pend_lo(pend_lo),
  .level_o(level_o), .vector_o(vector_o)
);

// File: tb/tb_irq_level_agg.sv
module tb_irq_level_agg;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_STAT = 16'h7000;
  localparam logic [15:0] A_MASK = 16'h7800;
  localparam logic [15:0] A_OTHR = 16'h7004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] src_i = '0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [15:0] rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic [2:0]  level_o;
  logic [7:0]  vector_o;

  int tests = 0, fails = 0;
  bit done = 0;

  // independent restatement of the source map (R2, R3)
  int bpos [13] = '{7, 3, 2, 9, 10, 12, 5, 17, 28, 27, 26, 23, 21};
  int bgrp [13] = '{3, 3, 3, 3, 3, 3, 3, 5, 6, 6, 6, 6, 6};

  irq_level_agg dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_level(input logic [31:0] st, input logic [31:0] mk);
    int best = 0;
    for (int i = 0; i < 13; i++)
      if (st[bpos[i]] && mk[bpos[i]] && bgrp[i] > best) best = bgrp[i];
    return best;
  endfunction

  function automatic int exp_vec(input int lv);
    return (lv == 0) ? 0 : 24 + lv - (lv == 3 ? 0 : 0) + (lv == 6 ? 0 : (lv == 5 ? 0 : 0));
  endfunction

  function automatic logic [31:0] place(input logic [12:0] s);
    logic [31:0] r = '0;
    for (int i = 0; i < 13; i++) if (s[i]) r |= 32'h1 << bpos[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    rd_addr_i = a; #1; d = rd_data_o;
  endtask

  task automatic check_out(input string req, input logic [31:0] st, input logic [31:0] mk);
    int lv;
    lv = exp_level(st, mk);
    check(req, {29'd0, level_o}, lv);
    // R11: vector values 27, 29, 30 for levels 3, 5, 6
    check(req, {24'd0, vector_o}, (lv == 3) ? 27 : (lv == 5) ? 29 : (lv == 6) ? 30 : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [12:0] s;
    repeat (3) tick();
    // R1 reset state (still in reset)
    rd(A_STAT, d); check("R1 status", d, 0);
    rd(A_MASK, d); check("R1 mask", d, 0);
    check("R1 level", level_o, 0);
    rst_n = 1'b1;
    tick();
    check("R1 vector", vector_o, 0);

    // R9: sources pending but enable all zero
    for (int i = 0; i < 13; i++) begin
      src_i = 13'h1 << i; tick();
      check("R9 masked-off level", level_o, 0);
      rd(A_STAT, d); check("R4 pending while masked", d, 32'h1 << bpos[i]);
    end

    // R6 enable write, R2/R3/R10/R11 single-source sweep
    bus_wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, d); check("R6 mask load", d, 32'hFFFF_FFFF);
    for (int i = 0; i < 13; i++) begin
      src_i = 13'h1 << i; tick();
      rd(A_STAT, d);
      check(i < 7 ? "R2 bit map" : "R3 bit map", d, 32'h1 << bpos[i]);
      check_out("R11 single source", d, 32'hFFFF_FFFF);
    end

    // R9 per-bit gating: only own bit enabled, then all but own bit
    for (int i = 0; i < 13; i++) begin
      src_i = 13'h1 << i;
      bus_wr(A_MASK, 32'h1 << bpos[i]);
      check_out("R9 own bit enabled", 32'h1 << bpos[i], 32'h1 << bpos[i]);
      bus_wr(A_MASK, ~(32'h1 << bpos[i]));
      check("R9 own bit disabled", level_o, 0);
    end

    // R10 priority across all group combinations
    bus_wr(A_MASK, 32'hFFFF_FFFF);
    for (int c = 0; c < 8; c++) begin
      s = '0;
      s[2]  = c[0];  // low group
      s[7]  = c[1];  // middle group
      s[10] = c[2];  // high group
      src_i = s; tick();
      check_out("R10 priority", place(s), 32'hFFFF_FFFF);
    end

    // R4 deassertion clears
    src_i = '0; tick();
    rd(A_STAT, d); check("R4 clear on deassert", d, 0);

    // R5 write override and recovery
    src_i = 13'h1 << 11;           // sound, bit 23
    tick();
    bus_wr(A_STAT, 32'h0000_0001); // unowned bit 0, owned bits zero
    rd(A_STAT, d); check("R5 override", d, 32'h0000_0001);
    check("R5 override level", level_o, 0);
    tick();
    rd(A_STAT, d); check("R5 recovery", d, 32'h0080_0001);
    src_i = '0;
    bus_wr(A_STAT, 32'h0000_1000); // owned bit 12, source low
    rd(A_STAT, d); check("R5 forced bit", d, 32'h0000_1000);
    check("R5 forced level", level_o, 3);
    tick();
    rd(A_STAT, d); check("R5 forced bit cleared", d, 0);
    bus_wr(A_STAT, 32'h4000_0000); // unowned bit 30 persists
    repeat (3) tick();
    rd(A_STAT, d); check("R4 unowned bit kept", d, 32'h4000_0000);

    // R7 other offset write ignored, R8 other offset reads zero
    bus_wr(A_OTHR, 32'h1234_5678);
    rd(A_STAT, d); check("R7 status untouched", d, 32'h4000_0000);
    rd(A_MASK, d); check("R7 mask untouched", d, 32'hFFFF_FFFF);
    rd(A_OTHR, d); check("R8 other offset read", d, 0);
    bus_wr(A_MASK, 32'h0F0F_0F0F);
    rd(A_MASK, d); check("R8 mask readback", d, 32'h0F0F_0F0F);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule